// File: doc/BRIEF.md
# Prioritized vectored interrupt arbiter

This block is the interrupt front end of a small CPU. It keeps a pending flag and an enable flag for each maskable source, and a global interrupt enable above them. It also keeps one hidden pending flag for a software trap that cannot be masked. When any qualified source is waiting it raises one request line. The core answers that request by branching to the single fixed entry address 0x00FF. The core does not choose the service routine at that moment.

The routine is chosen later. The code at the fixed entry runs a vector instruction, which strobes `vec_req`. The arbiter then compares all active sources and returns an even byte offset between 0xE0 and 0xFE. That offset points at a two-byte table entry: the high byte of the service address is stored at the even location and the low byte at the next odd location. Software owns the maskable pending flags. Only the return-from-interrupt strobe clears the trap flag.

Top module: `irq_vector_arb`

## Requirements
- R1: After reset all pending bits, all enable bits, the global enable and the trap flag are 0, `irq_o` is 0, `vec_valid_o` is 0 and `vec_off_o` is 0xE0.
- R2: A high `src_evt[i]` sets pending bit i at the next clock edge. A software write to the pending register in the same cycle cannot clear that bit.
- R3: When `cfg_wr` is high, `cfg_sel`=0 loads `cfg_wdata` into the enable register and `cfg_sel`=1 loads it into the pending register (OR-ed with any event in that cycle).
- R4: `irq_o` is high when the trap flag is set, or when the global enable is set and some source has both its pending and enable bits at 1. `irq_o` follows the registered state in the same cycle.
- R5: `int_take` clears the global enable at the next edge. `reti` sets it unless `int_take` is also high. `gie_wr` loads `gie_wdata` when neither strobe is high.
- R6: One cycle after `vec_req`, `vec_valid_o` pulses and `vec_off_o` = 0xFC − 2·i, where i is the lowest index whose pending and enable bits are both 1. Index 0 has the highest priority among the maskable sources.
- R7: While the trap flag is set, a vector request returns 0xFE whatever the maskable sources are doing.
- R8: A vector request with no active source and no trap returns 0xE0.
- R9: `trap_req` sets the trap flag. Only `reti` clears it, and a set in the same cycle wins. Writes to the pending or enable registers do not affect it.
- R10: `vec_off_o` is always even, lies in 0xE0..0xFE, and holds its value between vector requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | NUM_SRC | Per-source event pulses |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = enable register, 1 = pending register |
| cfg_wdata | input | NUM_SRC | Write data |
| gie_wr | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable write value |
| trap_req | input | 1 | Software trap executed |
| int_take | input | 1 | Core has accepted the interrupt |
| reti | input | 1 | Return-from-interrupt executed |
| vec_req | input | 1 | Vector instruction strobe |
| en_o | output | NUM_SRC | Enable register readback |
| pend_o | output | NUM_SRC | Pending register readback |
| gie_o | output | 1 | Global enable state |
| irq_o | output | 1 | Interrupt request to the core |
| vec_valid_o | output | 1 | Offset valid pulse |
| vec_off_o | output | 8 | Vector table offset |

## Verification
Register state (pending, enable, global enable, trap flag) changes at the edge that samples the strobe. The bench drives every stimulus at a falling edge and reads `pend_o`, `en_o`, `gie_o` and the combinational `irq_o` at the following falling edge. A vector offset is due one edge after `vec_req`, so the offset is also read at the next falling edge. The priority sweep covers every single source and every pair of sources, and computes the expected offset from the lowest active index.

// File: rtl/irq_arb_pkg.sv
// Package: shared constants and the offset formula for the vectored interrupt arbiter.
// Assumes byte offsets and a table that grows downward from the trap slot.
package irq_arb_pkg;
    localparam logic [7:0] OFF_TRAP    = 8'hFE;
    localparam logic [7:0] OFF_FIRST   = 8'hFC;
    localparam logic [7:0] OFF_DEFAULT = 8'hE0;
    localparam int         MAX_SRC     = 13;

    // Offset of maskable source idx (0 = most urgent).
    function automatic logic [7:0] src_offset(input int unsigned idx);
        return 8'(int'(OFF_FIRST) - 2 * int'(idx));
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
// Module: pending and enable flags for the maskable sources.
// Assumes events are single-cycle or level; an event always wins over a software clear.
module irq_pend_bank #(
    parameter int NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [NUM_SRC-1:0] cfg_wdata,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] pend_q
);
    // Enable register: loaded only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                  en_q <= '0;
        else if (cfg_wr && !cfg_sel) en_q <= cfg_wdata;
    end

    // Pending register: events set bits, software writes replace them.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend_q <= '0;
        else if (cfg_wr && cfg_sel) pend_q <= cfg_wdata | src_evt;
        else                        pend_q <= pend_q | src_evt;
    end

    p_evt_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));
    p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel) |=> (en_q == $past(cfg_wdata)));
endmodule

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority encoder; the lowest set index wins.
// Assumes NUM_SRC >= 2. Purely combinational.
module irq_prio_enc #(
    parameter int NUM_SRC = 13,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] active,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Scan from the least urgent source up, so the lowest index is written last.
    always_comb begin
        idx_o = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (active[k]) idx_o = IDX_W'(k);
        end
    end

    assign any_o = |active;
endmodule

// File: rtl/irq_gate_ctrl.sv
// Module: global interrupt enable and the hidden software-trap pending flag.
// Assumes int_take and reti come from the core as single-cycle strobes.
module irq_gate_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic gie_wr,
    input  logic gie_wdata,
    input  logic trap_req,
    input  logic int_take,
    input  logic reti,
    output logic gie_q,
    output logic trap_q
);
    // Global enable: acceptance clears it, return sets it, otherwise software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        gie_q <= 1'b0;
        else if (int_take) gie_q <= 1'b0;
        else if (reti)     gie_q <= 1'b1;
        else if (gie_wr)   gie_q <= gie_wdata;
    end

    // Trap flag: set by the trap instruction, cleared only by return.
    always_ff @(posedge clk) begin
        if (!rst_n)        trap_q <= 1'b0;
        else if (trap_req) trap_q <= 1'b1;
        else if (reti)     trap_q <= 1'b0;
    end

    p_take_clears_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |=> !gie_q);
    p_reti_sets_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !int_take) |=> gie_q);
    p_trap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_q && !reti) |=> trap_q);
    p_trap_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> trap_q);
endmodule

// File: rtl/irq_vector_arb.sv
// Module: top of the vectored interrupt arbiter. Raises one request and,
// on a vector instruction, registers the offset of the most urgent active source.
// Assumes the core branches to the fixed entry on irq_o and strobes vec_req from there.
module irq_vector_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [NUM_SRC-1:0] cfg_wdata,
    input  logic               gie_wr,
    input  logic               gie_wdata,
    input  logic               trap_req,
    input  logic               int_take,
    input  logic               reti,
    input  logic               vec_req,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               gie_o,
    output logic               irq_o,
    output logic               vec_valid_o,
    output logic [7:0]         vec_off_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] active;
    logic               any_act;
    logic [IDX_W-1:0]   win_idx;
    logic               trap_q;
    logic [7:0]         off_next;

    irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .en_q(en_o), .pend_q(pend_o)
    );

    irq_gate_ctrl u_gate (
        .clk(clk), .rst_n(rst_n), .gie_wr(gie_wr), .gie_wdata(gie_wdata),
        .trap_req(trap_req), .int_take(int_take), .reti(reti),
        .gie_q(gie_o), .trap_q(trap_q)
    );

    assign active = pend_o & en_o;

    irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
        .active(active), .any_o(any_act), .idx_o(win_idx)
    );

    // Request to the core: the trap cannot be masked, the others pass through the global enable.
    assign irq_o = trap_q | (gie_o & any_act);

    // Offset selection: trap first, then the winning source, else the default slot.
    always_comb begin
        if (trap_q)       off_next = OFF_TRAP;
        else if (any_act) off_next = src_offset(int'(win_idx));
        else              off_next = OFF_DEFAULT;
    end

    // Offset register: captured on the vector strobe and held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_o <= 1'b0;
            vec_off_o   <= OFF_DEFAULT;
        end else begin
            vec_valid_o <= vec_req;
            if (vec_req) vec_off_o <= off_next;
        end
    end

    initial begin
        assert (NUM_SRC >= 2 && NUM_SRC <= MAX_SRC);
    end

    p_off_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (!vec_off_o[0] && vec_off_o >= OFF_DEFAULT));
    p_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_req |=> $stable(vec_off_o));
    p_trap_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && trap_q) |=> (vec_off_o == OFF_TRAP));
    p_idle_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !trap_q && (pend_o & en_o) == '0) |=> (vec_off_o == OFF_DEFAULT));
    p_trap_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> irq_o);
endmodule

// File: tb/irq_vector_arb_tb.sv
module irq_vector_arb_tb_top;
    localparam int N = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_evt = '0;
    logic         cfg_wr = 1'b0;
    logic         cfg_sel = 1'b0;
    logic [N-1:0] cfg_wdata = '0;
    logic         gie_wr = 1'b0;
    logic         gie_wdata = 1'b0;
    logic         trap_req = 1'b0;
    logic         int_take = 1'b0;
    logic         reti = 1'b0;
    logic         vec_req = 1'b0;
    logic [N-1:0] en_o;
    logic [N-1:0] pend_o;
    logic         gie_o;
    logic         irq_o;
    logic         vec_valid_o;
    logic [7:0]   vec_off_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_vector_arb #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .gie_wr(gie_wr),
        .gie_wdata(gie_wdata), .trap_req(trap_req), .int_take(int_take),
        .reti(reti), .vec_req(vec_req), .en_o(en_o), .pend_o(pend_o),
        .gie_o(gie_o), .irq_o(irq_o), .vec_valid_o(vec_valid_o),
        .vec_off_o(vec_off_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: inputs already set at a falling edge, capture at the rising edge,
    // then clear the strobes at the next falling edge.
    task automatic cyc();
        @(negedge clk);
        src_evt = '0; cfg_wr = 0; gie_wr = 0; trap_req = 0;
        int_take = 0; reti = 0; vec_req = 0;
    endtask

    task automatic wr_reg(input bit sel, input logic [N-1:0] d);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = d; cyc();
    endtask

    task automatic do_vec();
        vec_req = 1; cyc();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pend", int'(pend_o), 0);
        chk("R1 en", int'(en_o), 0);
        chk("R1 gie", int'(gie_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 valid", int'(vec_valid_o), 0);
        chk("R1 off", int'(vec_off_o), 'hE0);

        // R8 nothing active
        do_vec();
        chk("R8 valid", int'(vec_valid_o), 1);
        chk("R8 off", int'(vec_off_o), 'hE0);

        // R2 event sets pending, and survives a same-cycle clearing write
        src_evt = N'(1) << 3; cyc();
        chk("R2 set", int'(pend_o), 1 << 3);
        src_evt = N'(1) << 5; cfg_wr = 1; cfg_sel = 1; cfg_wdata = '0; cyc();
        chk("R2 evt wins", int'(pend_o), 1 << 5);
        // R3 writes
        wr_reg(1, '0);
        chk("R3 pend clr", int'(pend_o), 0);
        wr_reg(0, N'('h1A5));
        chk("R3 en load", int'(en_o), 'h1A5);
        chk("R3 pend untouched", int'(pend_o), 0);

        // R4 gating
        wr_reg(0, '1);
        wr_reg(1, N'(1) << 7);
        chk("R4 gie off", int'(irq_o), 0);
        gie_wr = 1; gie_wdata = 1; cyc();
        chk("R5 gie write", int'(gie_o), 1);
        chk("R4 irq on", int'(irq_o), 1);
        wr_reg(0, '0);
        chk("R4 masked", int'(irq_o), 0);
        wr_reg(0, '1);
        // R5 take/reti
        int_take = 1; cyc();
        chk("R5 take", int'(gie_o), 0);
        chk("R4 after take", int'(irq_o), 0);
        reti = 1; cyc();
        chk("R5 reti", int'(gie_o), 1);
        int_take = 1; reti = 1; cyc();
        chk("R5 take beats reti", int'(gie_o), 0);

        // R6 single-source and pair sweep
        for (int i = 0; i < N; i++) begin
            wr_reg(1, N'(1) << i);
            do_vec();
            chk("R6 single", int'(vec_off_o), 'hFC - 2 * i);
            chk("R10 even", int'(vec_off_o[0]), 0);
        end
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                wr_reg(1, (N'(1) << i) | (N'(1) << j));
                do_vec();
                chk("R6 pair", int'(vec_off_o), 'hFC - 2 * i);
            end
        end
        // R6 enable masks the more urgent source
        wr_reg(1, N'('b101));
        wr_reg(0, N'('b100));
        do_vec();
        chk("R6 masked winner", int'(vec_off_o), 'hFC - 4);
        // R10 hold between requests
        wr_reg(1, N'(1) << 9);
        chk("R10 hold", int'(vec_off_o), 'hFC - 4);
        chk("R10 valid pulse", int'(vec_valid_o), 0);

        // R7/R9 trap
        wr_reg(0, '1);
        wr_reg(1, '1);
        trap_req = 1; cyc();
        chk("R9 trap irq with gie off", int'(irq_o), 1);
        do_vec();
        chk("R7 trap offset", int'(vec_off_o), 'hFE);
        wr_reg(1, '0);
        wr_reg(0, '0);
        do_vec();
        chk("R9 writes leave trap", int'(vec_off_o), 'hFE);
        chk("R9 irq kept", int'(irq_o), 1);
        trap_req = 1; reti = 1; cyc();
        chk("R9 set beats clear", int'(irq_o), 1);
        reti = 1; cyc();
        chk("R9 reti clears", int'(irq_o), 0);
        do_vec();
        chk("R8 after trap", int'(vec_off_o), 'hE0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule